// File: doc/BRIEF.md
# FIFO Reset Sequencer with Status Flags

This block governs the clearing of one FIFO that sits behind a shared, addressed port of a multi-port link interface. On every rising edge of the FIFO clock it samples three active-low controls: a port select, a clear request and a transfer enable. A clear is recognised only when the port is selected and the clear request is asserted, while the transfer enable stays idle. This qualified request must hold for a set number of consecutive edges. Once that count is reached, the block reports a forced full condition and blocks all writes. It stays in that condition until the requester withdraws, either by releasing the clear request or by deselecting the port.

When the request is withdrawn, the block issues a single-cycle pointer-clear command to the storage and reports the empty pattern. It then returns to passing the FIFO's own occupancy through as the empty, half and full flags. The flags count as driven only while the port is selected. Otherwise the enable is low and the values are held at zero, which stands in for a high-impedance bus. An asynchronous power-up reset clears the FIFO at once, with no clear sequence needed. The storage and the data path are outside the block. They appear only as an occupancy count input and the pointer-clear and write-block outputs. This block has no streaming data interface, so it has no valid/ready handshake.

Top module: `fifo_rst_seq`

## Requirements
- R1: A qualified request on an edge means sel_n=0, clr_req_n=0 and xfer_n=1. Only consecutive qualified edges advance the hold count.
- R2: The forced state begins right after the HOLD_CYCLES-th (default 8) consecutive qualified edge, and not after HOLD_CYCLES-1 edges.
- R3: Before the count completes, any edge with sel_n=1, clr_req_n=1 or xfer_n=0 abandons the sequence and clears the count. A later attempt then needs a fresh HOLD_CYCLES qualified edges, and no pointer clear is issued.
- R4: While xfer_n=0, a select plus a clear request is held off for any length of time. Counting begins only on edges after xfer_n returns to 1.
- R5: In the forced state, while driven, the flags read empty=0, half=1 and full=1, and wr_block=1.
- R6: The count saturates. Holding the request beyond HOLD_CYCLES edges keeps the forced state, with no restart and no pointer clear.
- R7: If the forced state is left by raising clr_req_n with the port still selected, then for exactly one cycle after that edge ptr_clr=1, wr_block=0 and the flags read empty=1, half=0 and full=0.
- R8: If the forced state is left by raising sel_n, flag_oe falls at once, and ptr_clr still pulses for one cycle after that edge. A later selected access without a clear request sees the cleared occupancy as empty.
- R9: flag_oe equals the inverse of sel_n. While flag_oe=0, all three flag outputs are 0.
- R10: Outside the forced state and the clear cycle, the flags follow occ: empty when occ=0, half when occ>=DEPTH/2 and full when occ>=DEPTH. wr_block stays 0 even with occ above DEPTH, which covers the four-write overrun slack of an ordinary full.
- R11: While rst_n=0, and up to the first clock edge after it rises, ptr_clr=1 and wr_block=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock, rising edge |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| sel_n | input | 1 | Port select, active low |
| clr_req_n | input | 1 | Clear request, active low |
| xfer_n | input | 1 | Transfer enable, active low |
| occ | input | OCC_W | FIFO occupancy from storage (0 to DEPTH+4) |
| flag_empty | output | 1 | Empty flag value |
| flag_half | output | 1 | Half flag value |
| flag_full | output | 1 | Full flag value |
| flag_oe | output | 1 | Flag drivers enabled |
| ptr_clr | output | 1 | Pointer-clear command to storage |
| wr_block | output | 1 | All writes refused (forced full) |

## Verification
The bench builds the block with the defaults, HOLD_CYCLES=8 and DEPTH=16. At that size the seventh and eighth qualified edges can be compared directly. An abort can be injected in the middle of a count, and a hold of twelve extra edges exercises the saturation. DEPTH=16 puts the half and full thresholds at occupancies of 8 and 16, and the 5-bit occ input allows values up to 20. This makes it possible to check that an ordinary full with overrun slack never sets wr_block.

// File: rtl/fifo_rst_pkg.sv
package fifo_rst_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FORCED = 2'd1,
    SEQ_DRAIN  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic empty;
    logic half;
    logic full;
  } flag_set_t;
endpackage

// File: rtl/rst_hold_counter.sv
module rst_hold_counter #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  assign hit = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import fifo_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qual,
  input  logic       held,
  input  logic       hit,
  output logic       run,
  output seq_state_e state
);
  seq_state_e state_q, state_d;

  assign state = state_q;
  assign run   = ((state_q == SEQ_IDLE) && qual) || ((state_q == SEQ_FORCED) && held);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (hit) state_d = SEQ_FORCED;
      SEQ_FORCED: if (!held) state_d = SEQ_DRAIN;
      SEQ_DRAIN:  state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_DRAIN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/flag_mux.sv
module flag_mux
  import fifo_rst_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OCC_W = 5
) (
  input  seq_state_e       state,
  input  logic [OCC_W-1:0] occ,
  input  logic             sel_n,
  output flag_set_t        flags,
  output logic             oe
);
  localparam logic [OCC_W-1:0] HALF_MARK = OCC_W'(DEPTH / 2);
  localparam logic [OCC_W-1:0] FULL_MARK = OCC_W'(DEPTH);

  flag_set_t live;

  always_comb begin
    live.empty = (occ == '0);
    live.half  = (occ >= HALF_MARK);
    live.full  = (occ >= FULL_MARK);
  end

  assign oe = !sel_n;

  always_comb begin
    flags = '0;
    if (oe) begin
      unique case (state)
        SEQ_FORCED: flags = '{empty: 1'b0, half: 1'b1, full: 1'b1};
        SEQ_DRAIN:  flags = '{empty: 1'b1, half: 1'b0, full: 1'b0};
        default:    flags = live;
      endcase
    end
  end
endmodule

// File: rtl/fifo_rst_seq.sv
module fifo_rst_seq
  import fifo_rst_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int DEPTH       = 16,
  parameter int OCC_W       = $clog2(DEPTH + 4 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             clr_req_n,
  input  logic             xfer_n,
  input  logic [OCC_W-1:0] occ,
  output logic             flag_empty,
  output logic             flag_half,
  output logic             flag_full,
  output logic             flag_oe,
  output logic             ptr_clr,
  output logic             wr_block
);
  logic       held, qual, run, hit;
  seq_state_e state;
  flag_set_t  flags;

  assign held = !sel_n && !clr_req_n;
  assign qual = held && xfer_n;

  rst_hold_counter #(.HOLD_CYCLES(HOLD_CYCLES)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(run), .hit(hit)
  );

  rst_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .qual(qual), .held(held),
    .hit(hit), .run(run), .state(state)
  );

  flag_mux #(.DEPTH(DEPTH), .OCC_W(OCC_W)) mux_i (
    .state(state), .occ(occ), .sel_n(sel_n), .flags(flags), .oe(flag_oe)
  );

  assign flag_empty = flags.empty;
  assign flag_half  = flags.half;
  assign flag_full  = flags.full;
  assign ptr_clr    = (state == SEQ_DRAIN);
  assign wr_block   = (state == SEQ_FORCED);
endmodule

// File: rtl/fifo_rst_seq_chk.sv
module fifo_rst_seq_chk #(
  parameter int HOLD_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic clr_req_n,
  input logic xfer_n,
  input logic flag_empty,
  input logic flag_half,
  input logic flag_full,
  input logic flag_oe,
  input logic ptr_clr,
  input logic wr_block
);
  localparam int RUN_W = $clog2(HOLD_CYCLES + 1);

  logic [RUN_W-1:0] streak_q;
  logic             good_edge;

  assign good_edge = !sel_n && !clr_req_n && xfer_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) streak_q <= '0;
    else if (!good_edge) streak_q <= '0;
    else if (streak_q != RUN_W'(HOLD_CYCLES)) streak_q <= streak_q + 1'b1;
  end

  // R2
  enough_streak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_block) |-> (streak_q == RUN_W'(HOLD_CYCLES)));

  // R5
  forced_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block && flag_oe) |-> (!flag_empty && flag_half && flag_full));

  // R6
  forced_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block && !sel_n && !clr_req_n) |=> wr_block);

  // R7
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_block && (sel_n || clr_req_n)) |=> (ptr_clr && !wr_block));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !ptr_clr);

  // R9
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_oe |-> !(flag_empty || flag_half || flag_full));
endmodule

bind fifo_rst_seq fifo_rst_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .clr_req_n(clr_req_n),
  .xfer_n(xfer_n), .flag_empty(flag_empty), .flag_half(flag_half),
  .flag_full(flag_full), .flag_oe(flag_oe), .ptr_clr(ptr_clr),
  .wr_block(wr_block)
);

// File: tb/fifo_rst_seq_tb_top.sv
module fifo_rst_seq_tb_top;
  localparam int HOLD  = 8;
  localparam int DEPTH = 16;
  localparam int OCC_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, clr_req_n = 1'b1, xfer_n = 1'b1;
  logic [OCC_W-1:0] occ = '0;
  logic flag_empty, flag_half, flag_full, flag_oe, ptr_clr, wr_block;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fifo_rst_seq #(.HOLD_CYCLES(HOLD), .DEPTH(DEPTH), .OCC_W(OCC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .clr_req_n(clr_req_n),
    .xfer_n(xfer_n), .occ(occ), .flag_empty(flag_empty), .flag_half(flag_half),
    .flag_full(flag_full), .flag_oe(flag_oe), .ptr_clr(ptr_clr),
    .wr_block(wr_block)
  );

  // observed vector: {oe, empty, half, full, ptr_clr, wr_block}
  task automatic expect6(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {flag_oe, flag_empty, flag_half, flag_full, ptr_clr, wr_block};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic drive(input logic s, input logic c, input logic x);
    sel_n = s; clr_req_n = c; xfer_n = x;
  endtask

  task automatic t_powerup;
    rst_n = 1'b0;
    edges(2);
    expect6("R11 during reset", 6'b0_000_10);
    rst_n = 1'b1;
    #1;
    expect6("R11 after release before edge", 6'b0_000_10);
    edges(1);
    expect6("R11 pulse gone", 6'b0_000_00);
  endtask

  task automatic t_normal_flags;
    drive(1'b0, 1'b1, 1'b1);
    occ = 5'd0;  #1; expect6("R10 empty occ0", 6'b1_100_00);
    occ = 5'd7;  #1; expect6("R10 below half", 6'b1_000_00);
    occ = 5'd8;  #1; expect6("R10 half", 6'b1_010_00);
    occ = 5'd16; #1; expect6("R10 full", 6'b1_011_00);
    occ = 5'd20; #1; expect6("R10 overrun slack no block", 6'b1_011_00);
    sel_n = 1'b1; #1; expect6("R9 deselected quiet", 6'b0_000_00);
    edges(1);
  endtask

  task automatic t_hold_and_release;
    occ = 5'd5;
    drive(1'b0, 1'b0, 1'b1);
    edges(HOLD - 1);
    expect6("R2 R1 not yet forced after 7", 6'b1_000_00);
    edges(1);
    expect6("R2 R5 forced after 8", 6'b1_011_01);
    edges(12);
    expect6("R6 saturated hold", 6'b1_011_01);
    clr_req_n = 1'b1;
    edges(1);
    expect6("R7 clear cycle", 6'b1_100_10);
    occ = 5'd0;
    edges(1);
    expect6("R7 pulse single", 6'b1_100_00);
  endtask

  task automatic t_abort;
    occ = 5'd3;
    drive(1'b0, 1'b0, 1'b1);
    edges(5);
    xfer_n = 1'b0;
    edges(1);
    expect6("R3 abort by transfer", 6'b1_000_00);
    xfer_n = 1'b1;
    edges(HOLD - 1);
    expect6("R3 fresh count not done", 6'b1_000_00);
    clr_req_n = 1'b1;
    edges(1);
    expect6("R3 abort by request no clear", 6'b1_000_00);
    clr_req_n = 1'b0;
    edges(3);
    sel_n = 1'b1;
    edges(1);
    expect6("R3 abort by deselect quiet", 6'b0_000_00);
    sel_n = 1'b0;
    edges(HOLD - 1);
    expect6("R3 after deselect abort", 6'b1_000_00);
    edges(1);
    expect6("R3 eventual forced", 6'b1_011_01);
    clr_req_n = 1'b1;
    edges(2);
  endtask

  task automatic t_holdoff;
    occ = 5'd2;
    drive(1'b0, 1'b0, 1'b0);
    edges(15);
    expect6("R4 held off by transfer", 6'b1_000_00);
    xfer_n = 1'b1;
    edges(HOLD - 1);
    expect6("R4 counting after release", 6'b1_000_00);
    edges(1);
    expect6("R4 forced", 6'b1_011_01);
  endtask

  task automatic t_deselect_release;
    sel_n = 1'b1;
    #1;
    expect6("R8 R9 oe falls at once", 6'b0_000_01);
    edges(1);
    expect6("R8 clear pulse undriven", 6'b0_000_10);
    occ = 5'd0;
    edges(1);
    expect6("R8 pulse single", 6'b0_000_00);
    drive(1'b0, 1'b1, 1'b1);
    #1;
    expect6("R8 later access sees empty", 6'b1_100_00);
    edges(1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    t_powerup();
    t_normal_flags();
    t_hold_and_release();
    t_abort();
    t_holdoff();
    t_deselect_release();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule